// File: doc/BRIEF.md
# Routed Legacy Interrupt Collector

This block gathers sixteen level-style device interrupt sources into a sticky status register. It qualifies them with a mask and a global enable. In routing mode, each qualified interrupt is steered by its own programmable 2-bit selector to one of four shared interrupt lines toward the interrupt fabric. The lines are combinational functions of the stored state, so they follow any register change without an extra pipeline stage.

When the `legacy_mode` input is high, the routing selectors are ignored and the four lines stay low. All qualified interrupts are then ORed into a single internal request. That request latches into a sticky, maskable, write-one-to-clear legacy status flag, and the single `legacy_irq` output mirrors this flag. Software uses a small word-wide register port to program control, mask and both routing words, and to read and clear both status registers.

Register addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | mask |
| 2 | status |
| 3 | route word A |
| 4 | route word B |
| 5 | legacy status |
| 6 | legacy mask |
| 7 | reads zero |

Top module: `irq_router_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, all four `irq_line` outputs are low and `legacy_irq` is low.
- R2: Source n (0..15) owns status bit (31 − n). A low-to-high change on `irq_src[n]` sets that bit at the next clock edge. The mask register uses the same layout.
- R3: Status bits 15..0 and mask bits 15..0 always read zero, and writes to them have no effect.
- R4: Writing a 1 to a status bit clears it. Without auto-clear, a status bit stays set after its source returns low. If a set and a clear fall in the same cycle, the set wins.
- R5: An interrupt is active when its status bit and its mask bit are both 1 and control bit 31 (enable) is 1. With the enable bit at 0, no interrupt is active and all lines are low.
- R6: In routing mode, the selector for source n < 14 is route word B bits [27−2n : 26−2n]. Source 14 uses route word A bits [23:22], and source 15 uses bits [21:20]. Line k is high exactly when at least one active interrupt has selector value k.
- R7: A write to a route word takes effect on `irq_line` from the clock edge that performs the write. No further cycle is needed.
- R8: With control bit 23 (auto-clear) set in routing mode, a high-to-low change on `irq_src[n]` clears status bit (31 − n) at the next clock edge, and the lines follow.
- R9: In legacy mode, control bit 23 has no effect. Status bits stay set when their sources fall.
- R10: In legacy mode, all `irq_line` outputs are low and route-word contents have no effect. On each clock edge, while any interrupt is active and legacy-mask bit 0 is 1, legacy-status bit 0 becomes 1. `legacy_irq` equals legacy-status bit 0. With legacy-mask bit 0 at 0, nothing latches.
- R11: Legacy-status bit 0 is sticky: it stays set once the interrupts go inactive. Writing a 1 to bit 0 clears it.
- R12: In routing mode, `legacy_irq` is low and the legacy-status register is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | 1 selects the single-output latched path |
| irq_src | input | 16 | Interrupt sources, bit n is source n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_line | output | 4 | Routed interrupt lines |
| legacy_irq | output | 1 | Single latched legacy request |

## Verification
The bench sweeps every source against every selector value. A design that swaps the bit order, or that puts sources 14 and 15 in the wrong route word, raises the wrong line. Randomised patterns of status, mask and routes are compared with a line function computed in the bench, which catches a missing enable or mask term. Separate cases hit three things: the auto-clear flag, which must work only in routing mode; the sticky legacy flag, which must survive the interrupt going away; and the dead low half of the status word. A design that clears on a fall in legacy mode, or that drops the legacy flag without a software clear, fails these cases.

// File: rtl/irq_router_pkg.sv
// Shared constants for the routed legacy interrupt collector.
// Assumes 2-bit selectors and the fixed split of selectors over two route words.
package irq_router_pkg;
    localparam int SEL_W       = 2;   // selector width per source
    localparam int ROUTE_SPLIT = 14;  // sources below this use route word B
    localparam int ROUTE_B_TOP = 27;  // top bit of source 0 selector in word B
    localparam int ROUTE_A_TOP = 23;  // top bit of source 14 selector in word A
    localparam int CTRL_EN_BIT = 31;  // global enable
    localparam int CTRL_AC_BIT = 23;  // auto-clear on source fall

    localparam int REG_CTRL    = 0;
    localparam int REG_MASK    = 1;
    localparam int REG_STAT    = 2;
    localparam int REG_ROUTE_A = 3;
    localparam int REG_ROUTE_B = 4;
    localparam int REG_LSTAT   = 5;
    localparam int REG_LMASK   = 6;
endpackage

// File: rtl/irq_src_status.sv
// Per-source sticky status bits with edge detection.
// Bit (REG_W-1-n) belongs to source n. A rising source sets its bit; a falling
// source clears it when auto_clr is high; otherwise a write-one clears it.
// Set has priority over any clear. Bits below the source field are constant 0.
module irq_src_status #(
    parameter int NUM_SRC = 16,
    parameter int REG_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic             auto_clr,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] status
);
    localparam int LOW_W = REG_W - NUM_SRC;

    logic [NUM_SRC-1:0] prev_q;

    // Remember last source levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
        localparam int B = REG_W - 1 - n;
        logic bit_q;
        logic rise, fall;
        assign rise = src[n] & ~prev_q[n];
        assign fall = ~src[n] & prev_q[n];

        // Update one status bit: set beats auto-clear beats software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                  bit_q <= 1'b0;
            else if (rise)               bit_q <= 1'b1;
            else if (auto_clr && fall)   bit_q <= 1'b0;
            else if (wr_clr && clr_data[B]) bit_q <= 1'b0;
        end
        assign status[B] = bit_q;
    end

    if (LOW_W > 0) begin : g_low
        assign status[LOW_W-1:0] = '0;
    end
endmodule

// File: rtl/irq_route_matrix.sv
// Steers each active source to one of NUM_LINES outputs.
// Selector for source n < ROUTE_SPLIT sits in route_b, the rest in route_a,
// each two bits lower than the previous source. Purely combinational.
module irq_route_matrix
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int NUM_LINES = 4,
    parameter int REG_W     = 32
) (
    input  logic [NUM_SRC-1:0]   active,
    input  logic [REG_W-1:0]     route_a,
    input  logic [REG_W-1:0]     route_b,
    output logic [NUM_LINES-1:0] lines
);
    logic [SEL_W-1:0] sel [NUM_SRC];

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_sel
        if (n < ROUTE_SPLIT) begin : g_b
            assign sel[n] = route_b[ROUTE_B_TOP - SEL_W*n -: SEL_W];
        end else begin : g_a
            assign sel[n] = route_a[ROUTE_A_TOP - SEL_W*(n-ROUTE_SPLIT) -: SEL_W];
        end
    end

    // OR every active source into the line its selector names.
    always_comb begin
        lines = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (active[n]) lines[sel[n]] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_legacy_latch.sv
// Single-output legacy path: a request bit (any interrupt active while in
// legacy mode) latches into a sticky flag through its mask; a write-one
// clears it, and a new latch wins over a clear in the same cycle.
module irq_legacy_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic any_active,
    input  logic lmask,
    input  logic wr_clr,
    input  logic clr_bit,
    output logic sticky,
    output logic irq
);
    logic req;
    assign req = mode_en & any_active;

    // Sticky flag: latch masked request, else honour write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               sticky <= 1'b0;
        else if (req && lmask)    sticky <= 1'b1;
        else if (wr_clr && clr_bit) sticky <= 1'b0;
    end

    assign irq = sticky & mode_en;
endmodule

// File: rtl/irq_router_top.sv
// Routed legacy interrupt collector, top level.
// Holds the control, mask, route and legacy-mask registers, qualifies the
// status bits and selects routed or legacy output. Register reads are
// combinational on reg_addr; writes happen on the clock edge with reg_wr.
module irq_router_top
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int NUM_LINES = 4,
    parameter int REG_W     = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 legacy_mode,
    input  logic [NUM_SRC-1:0]   irq_src,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] irq_line,
    output logic                 legacy_irq
);
    localparam int LOW_W = REG_W - NUM_SRC;

    logic [REG_W-1:0]   ctrl_q, route_a_q, route_b_q;
    logic [NUM_SRC-1:0] mask_hi_q;
    logic               lmask_q;
    logic [REG_W-1:0]   status;
    logic [REG_W-1:0]   mask_full;
    logic               lsticky;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] routed_active;

    logic wr_ctrl, wr_mask, wr_stat, wr_ra, wr_rb, wr_lstat, wr_lmask;
    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
    assign wr_mask  = reg_wr && (reg_addr == ADDR_W'(REG_MASK));
    assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(REG_STAT));
    assign wr_ra    = reg_wr && (reg_addr == ADDR_W'(REG_ROUTE_A));
    assign wr_rb    = reg_wr && (reg_addr == ADDR_W'(REG_ROUTE_B));
    assign wr_lstat = reg_wr && (reg_addr == ADDR_W'(REG_LSTAT));
    assign wr_lmask = reg_wr && (reg_addr == ADDR_W'(REG_LMASK));

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            mask_hi_q <= '0;
            route_a_q <= '0;
            route_b_q <= '0;
            lmask_q   <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_q    <= reg_wdata;
            if (wr_mask)  mask_hi_q <= reg_wdata[REG_W-1 -: NUM_SRC];
            if (wr_ra)    route_a_q <= reg_wdata;
            if (wr_rb)    route_b_q <= reg_wdata;
            if (wr_lmask) lmask_q   <= reg_wdata[0];
        end
    end

    if (LOW_W > 0) begin : g_mask_low
        assign mask_full = {mask_hi_q, {LOW_W{1'b0}}};
    end else begin : g_mask_full
        assign mask_full = mask_hi_q;
    end

    irq_src_status #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .auto_clr (ctrl_q[CTRL_AC_BIT] & ~legacy_mode),
        .wr_clr   (wr_stat),
        .clr_data (reg_wdata),
        .status   (status)
    );

    // Qualify each source by mask and global enable.
    always_comb begin
        for (int n = 0; n < NUM_SRC; n++) begin
            active[n] = status[REG_W-1-n] & mask_full[REG_W-1-n] & ctrl_q[CTRL_EN_BIT];
        end
    end

    assign routed_active = active & {NUM_SRC{~legacy_mode}};

    irq_route_matrix #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_route (
        .active  (routed_active),
        .route_a (route_a_q),
        .route_b (route_b_q),
        .lines   (irq_line)
    );

    irq_legacy_latch u_legacy (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (legacy_mode),
        .any_active (|active),
        .lmask      (lmask_q),
        .wr_clr     (wr_lstat),
        .clr_bit    (reg_wdata[0]),
        .sticky     (lsticky),
        .irq        (legacy_irq)
    );

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(REG_CTRL):    reg_rdata = ctrl_q;
            ADDR_W'(REG_MASK):    reg_rdata = mask_full;
            ADDR_W'(REG_STAT):    reg_rdata = status;
            ADDR_W'(REG_ROUTE_A): reg_rdata = route_a_q;
            ADDR_W'(REG_ROUTE_B): reg_rdata = route_b_q;
            ADDR_W'(REG_LSTAT):   reg_rdata = {{(REG_W-1){1'b0}}, lsticky};
            ADDR_W'(REG_LMASK):   reg_rdata = {{(REG_W-1){1'b0}}, lmask_q};
            default:              reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
// Temporal checks for irq_router_top, attached by bind.
// Assumes the default 16-source, 32-bit configuration for bit positions.
module irq_router_chk #(
    parameter int NUM_SRC   = 16,
    parameter int NUM_LINES = 4,
    parameter int REG_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 legacy_mode,
    input logic [NUM_SRC-1:0]   irq_src,
    input logic [NUM_LINES-1:0] irq_line,
    input logic                 legacy_irq,
    input logic [REG_W-1:0]     status,
    input logic [REG_W-1:0]     ctrl_q
);
    localparam int LOW_W = REG_W - NUM_SRC;

    assert_low_half_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status[LOW_W-1:0] == '0);

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src[0] && !$past(irq_src[0])) |=> status[REG_W-1]);

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[31] |-> (irq_line == '0));

    assert_legacy_lines_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |-> (irq_line == '0));

    assert_routing_no_legacy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |-> !legacy_irq);

    assert_autoclear_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_mode && ctrl_q[23] && !irq_src[0] && $past(irq_src[0]))
        |=> !status[REG_W-1]);
endmodule

bind irq_router_top irq_router_chk #(
    .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .REG_W(REG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .legacy_mode(legacy_mode),
    .irq_src    (irq_src),
    .irq_line   (irq_line),
    .legacy_irq (legacy_irq),
    .status     (status),
    .ctrl_q     (ctrl_q)
);

// File: tb/irq_router_top_tb_top.sv
`timescale 1ns/1ps
module irq_router_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b0;
    logic [15:0] irq_src = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_line;
    logic        legacy_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_router_top dut_i (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .irq_src(irq_src),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_line(irq_line), .legacy_irq(legacy_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    // Status word image for a set of sources: source n -> bit 31-n.
    function automatic logic [31:0] src2stat(input logic [15:0] s);
        logic [31:0] r = '0;
        for (int n = 0; n < 16; n++) if (s[n]) r[31-n] = 1'b1;
        return r;
    endfunction

    function automatic int sel_of(input int n, input logic [31:0] ra, input logic [31:0] rb);
        if (n < 14) return int'((rb >> (26 - 2*n)) & 32'd3);
        return int'((ra >> (50 - 2*n)) & 32'd3);
    endfunction

    function automatic logic [3:0] exp_lines(input logic [15:0] st, input logic [15:0] mk,
                                             input bit en, input logic [31:0] ra,
                                             input logic [31:0] rb);
        logic [3:0] l = '0;
        for (int n = 0; n < 16; n++)
            if (en && st[n] && mk[n]) l[sel_of(n, ra, rb)] = 1'b1;
        return l;
    endfunction

    function automatic logic [31:0] route_word(input int n, input int r, input bit want_a);
        if (n < 14) return want_a ? 32'h0 : (32'(r) << (26 - 2*n));
        return want_a ? (32'(r) << (50 - 2*n)) : 32'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] seed = 32'h1234_5678;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, d); check("R1 reg reset", d, 32'h0);
        end
        check("R1 lines", {28'h0, irq_line}, 32'h0);
        check("R1 legacy", {31'h0, legacy_irq}, 32'h0);

        // R3 dead low half of status and mask
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); check("R3 mask low half", d, 32'hFFFF_0000);
        irq_src = 16'hFFFF; tick(); irq_src = 16'h0; tick();
        rd(2, d); check("R3 status all set low zero", d, 32'hFFFF_0000);
        wr(2, 32'h0000_FFFF);
        rd(2, d); check("R3 low write no effect", d, 32'hFFFF_0000);
        wr(2, 32'hFFFF_FFFF);
        rd(2, d); check("R4 w1c all", d, 32'h0);

        // R5 enable off: status and mask set, lines low
        irq_src = 16'h0001; tick(); irq_src = 16'h0; tick();
        check("R5 disabled lines", {28'h0, irq_line}, 32'h0);
        wr(0, 32'h8000_0000);
        check("R5 enabled line0", {28'h0, irq_line}, 32'h1);
        wr(1, 32'h0);
        check("R5 mask off", {28'h0, irq_line}, 32'h0);
        wr(1, 32'hFFFF_0000);
        wr(2, 32'hFFFF_0000);

        // R2 R6 R7 sweep every source over every selector value
        for (int n = 0; n < 16; n++) begin
            for (int r = 0; r < 4; r++) begin
                wr(3, route_word(n, r, 1'b1));
                wr(4, route_word(n, r, 1'b0));
                irq_src = 16'(1 << n); tick(); irq_src = 16'h0; tick();
                rd(2, d); check($sformatf("R2 status src%0d", n), d, 32'h1 << (31 - n));
                check($sformatf("R6 line src%0d sel%0d", n, r), {28'h0, irq_line}, 32'h1 << r);
                if (n < 14) wr(4, route_word(n, (r + 1) % 4, 1'b0));
                else        wr(3, route_word(n, (r + 1) % 4, 1'b1));
                check($sformatf("R7 reroute src%0d", n), {28'h0, irq_line}, 32'h1 << ((r + 1) % 4));
                wr(2, 32'hFFFF_0000);
            end
        end

        // R6 R5 random patterns against bench line model
        for (int it = 0; it < 40; it++) begin
            logic [15:0] sp, mp;
            logic [31:0] ra, rb;
            bit en;
            seed = seed * 32'd1103515245 + 32'd12345; sp = seed[31:16];
            seed = seed * 32'd1103515245 + 32'd12345; mp = seed[31:16];
            seed = seed * 32'd1103515245 + 32'd12345; ra = seed;
            seed = seed * 32'd1103515245 + 32'd12345; rb = seed;
            en = (it % 5) != 0;
            wr(0, en ? 32'h8000_0000 : 32'h0);
            wr(1, src2stat(mp));
            wr(3, ra); wr(4, rb);
            wr(2, 32'hFFFF_0000);
            irq_src = sp; tick(); irq_src = 16'h0; tick();
            rd(2, d); check("R4 sticky pattern", d, src2stat(sp));
            check("R6 random lines", {28'h0, irq_line}, {28'h0, exp_lines(sp, mp, en, ra, rb)});
        end

        // R4 set wins over same-cycle w1c
        wr(0, 32'h8000_0000); wr(1, 32'hFFFF_0000); wr(3, 0); wr(4, 0);
        wr(2, 32'hFFFF_0000);
        irq_src = 16'h0004;
        wr(2, 32'h2000_0000);
        rd(2, d); check("R4 set beats clear", d, 32'h2000_0000);
        irq_src = 16'h0; tick();
        rd(2, d); check("R4 held without autoclear", d, 32'h2000_0000);
        wr(2, 32'h2000_0000);
        rd(2, d); check("R4 w1c single", d, 32'h0);

        // R8 auto-clear in routing mode
        wr(0, 32'h8080_0000);
        wr(4, 32'h3 << (26 - 10));
        irq_src = 16'h0020; tick();
        rd(2, d); check("R8 set", d, 32'h0400_0000);
        check("R8 line3 up", {28'h0, irq_line}, 32'h8);
        irq_src = 16'h0; tick();
        rd(2, d); check("R8 auto cleared", d, 32'h0);
        check("R8 line down", {28'h0, irq_line}, 32'h0);
        check("R12 legacy low routing", {31'h0, legacy_irq}, 32'h0);

        // R10 legacy path
        legacy_mode = 1'b1;
        wr(6, 32'h1);
        irq_src = 16'h0020; tick(); tick();
        check("R10 legacy asserted", {31'h0, legacy_irq}, 32'h1);
        check("R10 lines low", {28'h0, irq_line}, 32'h0);
        rd(5, d); check("R10 lstat", d, 32'h1);
        // R9 auto-clear ignored in legacy mode
        irq_src = 16'h0; tick();
        rd(2, d); check("R9 no autoclear", d, 32'h0400_0000);
        wr(4, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
        check("R10 routes no effect", {28'h0, irq_line}, 32'h0);
        // R12 routing mode hides legacy flag and stops updates
        legacy_mode = 1'b0; #1;
        check("R12 legacy hidden", {31'h0, legacy_irq}, 32'h1 & 32'h0);
        check("R9 lines back in routing", {28'h0, irq_line}, 32'h8);
        wr(5, 32'h1);
        tick();
        rd(5, d); check("R12 no relatch in routing", d, 32'h0);
        legacy_mode = 1'b1;
        tick(); tick();
        check("R10 relatch", {31'h0, legacy_irq}, 32'h1);
        // R11 sticky after interrupt inactive, then w1c
        wr(2, 32'hFFFF_0000); tick();
        rd(2, d); check("R11 status cleared", d, 32'h0);
        check("R11 sticky held", {31'h0, legacy_irq}, 32'h1);
        wr(5, 32'h1);
        check("R11 w1c", {31'h0, legacy_irq}, 32'h0);
        // R10 legacy mask off: no latch
        wr(6, 32'h0);
        irq_src = 16'h8000; tick(); tick(); tick();
        check("R10 masked no latch", {31'h0, legacy_irq}, 32'h0);
        rd(5, d); check("R10 lstat masked", d, 32'h0);
        irq_src = 16'h0;
        legacy_mode = 1'b0;

        // R1 reset clears everything again
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        for (int a = 0; a < 8; a++) begin
            rd(a, d); check("R1 re-reset", d, 32'h0);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule